// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides its input clock by a ratio kept in a bit field of a 32-bit control word. A single-cycle write strobe loads the word, and the stored word is always visible on a read bus. Parameters choose where the field sits, how wide it is and which encoding turns the raw field into a divisor. The encodings are plus-one, raw with zero illegal, raw with zero meaning bypass, power of two, and raw with zero meaning the largest divisor.

The block drives two outputs. The first is a one-cycle clock-enable strobe on the last input cycle of every output period. The second is a divided clock that is high for the first half of each period, rounded up, and that follows the input clock directly when the divisor is one. It also reports the divisor now in force, and an error flag while the field holds an illegal zero.

A newly programmed divisor only replaces the running one at a period boundary, so no short period is ever produced. Two build options change how writes behave. In masked-write mode, the upper half-word of a write acts as a per-bit enable for the lower half. In locked mode, writes cannot alter the divisor field.

Top module: `prog_clk_divider`

## Requirements
- R1: With encoding 0 (plus-one), the divisor is the field value plus one.
- R2: With encoding 1 (raw), the divisor is the field value. A zero field is illegal: `err_o` is high while the field is zero, and the divisor in force stays the last legal one.
- R3: With encoding 2 (raw, zero bypass), a zero field gives divisor 1, and `div_pulse_o` is then high on every cycle.
- R4: With encoding 3 (power of two), the divisor is 2 raised to the field value.
- R5: With encoding 4 (max at zero), the divisor is the field value, except that a zero field gives 2^FIELD_W.
- R6: With HW_MASK set, a write changes lower bit i only when write bit 16+i is 1. Bits 31:16 always read as zero.
- R7: With READ_ONLY set, writes leave the field bits FIELD_LSB +: FIELD_W unchanged. The other bits are still written.
- R8: Without either option, a write stores all 32 bits, and `rd_data_o` shows them after the write edge. The field is read from bits FIELD_LSB +: FIELD_W.
- R9: `cur_div_o` changes only on the edge that ends a period. That is the edge at which `div_pulse_o` was high.
- R10: With divisor D, `div_pulse_o` is high on exactly the last cycle of every D-cycle period.
- R11: With D of 2 or more, `div_clk_o` is high for the first (D+1)/2 cycles (integer division) of each period. With D of 1, it follows `clk_i`.
- R12: During reset the control word equals RST_CTRL, `cur_div_o` is 1 and `div_pulse_o` is high. The divisor decoded from the reset field is in force after the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Stored control word |
| div_pulse_o | output | 1 | Clock-enable strobe, last cycle of each period |
| div_clk_o | output | 1 | Divided clock, about 50% duty |
| cur_div_o | output | div_w(ENC, FIELD_W) | Divisor in force |
| err_o | output | 1 | Field holds an illegal zero |

## Verification
`rd_data_o` and `err_o` are due one edge after the write strobe. The bench samples them at the falling edge that follows. `cur_div_o` is due at the first edge taken while `div_pulse_o` is high. So after each write the bench waits at falling edges for the strobe, steps one more falling edge, and only then compares the divisor. It then walks one whole period at falling edges. Over that period it expects the strobe only at the position D-1 and counts the high samples of `div_clk_o`.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;
  localparam int ENC_PLUS1       = 0;
  localparam int ENC_RAW         = 1;
  localparam int ENC_RAW_BYPASS  = 2;
  localparam int ENC_POW2        = 3;
  localparam int ENC_MAX_AT_ZERO = 4;

  // Bits needed to hold the largest divisor an encoding can produce
  function automatic int div_w(input int enc, input int fw);
    return (enc == ENC_POW2) ? (1 << fw) : fw + 1;
  endfunction
endpackage

// File: rtl/regdiv_ctrl_reg.sv
module regdiv_ctrl_reg #(
  parameter int          FIELD_LSB = 8,
  parameter int          FIELD_W   = 4,
  parameter bit          HW_MASK   = 1'b0,
  parameter bit          READ_ONLY = 1'b0,
  parameter logic [31:0] RST_CTRL  = 32'h0000_0100
) (
  input  logic        clk_i,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o
);
  localparam logic [31:0] FIELD_MASK = ((32'h1 << FIELD_W) - 32'h1) << FIELD_LSB;
  localparam logic [31:0] KEEP_MASK  = READ_ONLY ? FIELD_MASK : 32'h0;
  localparam logic [31:0] LIVE_BITS  = HW_MASK ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  logic [31:0] ctrl_q;
  logic [31:0] bit_en;
  logic [31:0] ctrl_next;

  always_comb begin
    bit_en    = (HW_MASK ? {16'h0, wr_data_i[31:16]} : 32'hFFFF_FFFF) & ~KEEP_MASK;
    ctrl_next = ((ctrl_q & ~bit_en) | (wr_data_i & bit_en)) & LIVE_BITS;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n)       ctrl_q <= RST_CTRL & LIVE_BITS;
    else if (wr_en_i) ctrl_q <= ctrl_next;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/regdiv_decode.sv
module regdiv_decode #(
  parameter int ENC     = 0,
  parameter int FIELD_W = 4,
  parameter int DIV_W   = 5
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   div_o,
  output logic               illegal_o
);
  import regdiv_pkg::*;

  // {illegal, divisor}
  function automatic logic [DIV_W:0] map_field(input logic [FIELD_W-1:0] f);
    logic [DIV_W-1:0] d;
    logic             bad;
    bad = 1'b0;
    case (ENC)
      ENC_RAW: begin
        bad = (f == '0);
        d   = bad ? DIV_W'(1) : DIV_W'(f);
      end
      ENC_RAW_BYPASS:  d = (f == '0) ? DIV_W'(1) : DIV_W'(f);
      ENC_POW2:        d = DIV_W'(1) << f;
      ENC_MAX_AT_ZERO: d = (f == '0) ? DIV_W'(2 ** FIELD_W) : DIV_W'(f);
      default:         d = DIV_W'(f) + DIV_W'(1);
    endcase
    return {bad, d};
  endfunction

  assign {illegal_o, div_o} = map_field(field_i);
endmodule

// File: rtl/regdiv_counter.sv
module regdiv_counter #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] next_div_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             period_end_o,
  output logic             div_clk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;

  function automatic logic [DIV_W:0] high_len(input logic [DIV_W-1:0] d);
    return ({1'b0, d} + (DIV_W+1)'(1)) >> 1;
  endfunction

  assign period_end_o = (cnt_q == act_q - DIV_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= DIV_W'(1);
    end else if (period_end_o) begin
      cnt_q <= '0;
      act_q <= next_div_i;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign act_div_o = act_q;
  assign div_clk_o = (act_q == DIV_W'(1)) ? clk_i : ({1'b0, cnt_q} < high_len(act_q));
endmodule

// File: rtl/prog_clk_divider.sv
module prog_clk_divider #(
  parameter int          FIELD_LSB = 8,
  parameter int          FIELD_W   = 4,
  parameter int          ENC       = regdiv_pkg::ENC_PLUS1,
  parameter bit          HW_MASK   = 1'b0,
  parameter bit          READ_ONLY = 1'b0,
  parameter logic [31:0] RST_CTRL  = 32'h0000_0100
) (
  input  logic        clk_i,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        div_pulse_o,
  output logic        div_clk_o,
  output logic [regdiv_pkg::div_w(ENC, FIELD_W)-1:0] cur_div_o,
  output logic        err_o
);
  localparam int DIV_W = regdiv_pkg::div_w(ENC, FIELD_W);

  logic [31:0]      ctrl;
  logic [DIV_W-1:0] dec_div;
  logic             dec_bad;
  logic [DIV_W-1:0] legal_q;
  logic [DIV_W-1:0] next_div;
  logic             period_end;

  regdiv_ctrl_reg #(
    .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .HW_MASK(HW_MASK),
    .READ_ONLY(READ_ONLY), .RST_CTRL(RST_CTRL)
  ) u_ctrl (
    .clk_i(clk_i), .rst_n(rst_n), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl)
  );

  regdiv_decode #(.ENC(ENC), .FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_dec (
    .field_i(ctrl[FIELD_LSB +: FIELD_W]), .div_o(dec_div), .illegal_o(dec_bad)
  );

  // Last legal divisor survives an illegal field
  assign next_div = dec_bad ? legal_q : dec_div;

  always_ff @(posedge clk_i) begin
    if (!rst_n) legal_q <= DIV_W'(1);
    else        legal_q <= next_div;
  end

  regdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i(clk_i), .rst_n(rst_n), .next_div_i(next_div),
    .act_div_o(cur_div_o), .period_end_o(period_end), .div_clk_o(div_clk_o)
  );

  assign div_pulse_o = period_end;
  assign rd_data_o   = ctrl;
  assign err_o       = dec_bad;
endmodule

// File: rtl/regdiv_chk.sv
module regdiv_chk #(
  parameter int FIELD_W   = 4,
  parameter int DIV_W     = 5,
  parameter bit HW_MASK   = 1'b0,
  parameter bit READ_ONLY = 1'b0
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               div_pulse_o,
  input logic [DIV_W-1:0]   cur_div_o,
  input logic               err_o,
  input logic [FIELD_W-1:0] rd_field,
  input logic [15:0]        rd_upper,
  input logic               period_end
);
  // R9
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !period_end |=> $stable(cur_div_o));
  // R10
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_pulse_o |=> (!div_pulse_o || cur_div_o == DIV_W'(1)));
  // R2
  err_field_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> (rd_field == '0));
  // R2
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cur_div_o != '0);
  // R6
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (HW_MASK != 1'b0) |-> (rd_upper == 16'h0));
  // R7
  locked_field_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (READ_ONLY != 1'b0) |-> $stable(rd_field));
endmodule

bind prog_clk_divider regdiv_chk #(
  .FIELD_W(FIELD_W), .DIV_W(DIV_W), .HW_MASK(HW_MASK), .READ_ONLY(READ_ONLY)
) u_regdiv_chk (
  .clk_i(clk_i), .rst_n(rst_n), .div_pulse_o(div_pulse_o), .cur_div_o(cur_div_o),
  .err_o(err_o), .rd_field(rd_data_o[FIELD_LSB +: FIELD_W]),
  .rd_upper(rd_data_o[31:16]), .period_end(period_end)
);

// File: tb/prog_clk_divider_bench.sv
module prog_clk_divider_bench;
  localparam int N      = 7;
  localparam int LSB    = 2;
  localparam int FW     = 3;
  localparam int ENC_T  [N] = '{0, 1, 2, 3, 4, 0, 0};
  localparam bit HW_T   [N] = '{0, 0, 0, 0, 0, 1, 0};
  localparam bit RO_T   [N] = '{0, 0, 0, 0, 0, 0, 1};
  localparam logic [31:0] RSTV = 32'h0000_0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wr_en = '0;
  logic [31:0]  wr_data = '0;
  logic         pulse_a [N];
  logic         dclk_a  [N];
  logic         err_a   [N];
  logic [31:0]  rd_a    [N];
  logic [15:0]  cur_a   [N];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] shadow [N];
  int          held   [N];

  always #4 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dut
    localparam int DW = regdiv_pkg::div_w(ENC_T[g], FW);
    logic [DW-1:0] cur;
    prog_clk_divider #(
      .FIELD_LSB(LSB), .FIELD_W(FW), .ENC(ENC_T[g]),
      .HW_MASK(HW_T[g]), .READ_ONLY(RO_T[g]), .RST_CTRL(RSTV)
    ) u_prog_clk_divider (
      .clk_i(clk), .rst_n(rst_n), .wr_en_i(wr_en[g]), .wr_data_i(wr_data),
      .rd_data_o(rd_a[g]), .div_pulse_o(pulse_a[g]), .div_clk_o(dclk_a[g]),
      .cur_div_o(cur), .err_o(err_a[g])
    );
    assign cur_a[g] = 16'(cur);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 marks an illegal field
  function automatic int exp_div(input int mode, input int f);
    case (mode)
      1:       return f;
      2:       return (f == 0) ? 1 : f;
      3:       return 1 << f;
      4:       return (f == 0) ? (1 << FW) : f;
      default: return f + 1;
    endcase
  endfunction

  function automatic string req_of(input int mode);
    case (mode)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic do_write(input int i, input logic [31:0] d);
    logic [31:0] m;
    m = HW_T[i] ? {16'h0, d[31:16]} : 32'hFFFF_FFFF;
    if (RO_T[i]) m = m & ~(32'h7 << LSB);
    shadow[i] = (shadow[i] & ~m) | (d & m);
    if (HW_T[i]) shadow[i][31:16] = 16'h0;
    @(negedge clk);
    wr_data  = d;
    wr_en[i] = 1'b1;
    @(negedge clk);
    wr_en    = '0;
  endtask

  task automatic sweep_one(input int i, input int f);
    logic [31:0] d;
    int fld, dv, bad, hi, pmiss, hexp;
    bit seen;
    string rq;
    if (HW_T[i]) d = {(f == 3) ? 16'h0000 : 16'h001D, 16'(f << LSB) | 16'h0003};
    else         d = 32'hA5A5_0002 | (32'(f) << LSB);
    do_write(i, d);
    rq = HW_T[i] ? "R6" : (RO_T[i] ? "R7" : "R8");
    check(rd_a[i] == shadow[i], rq, int'(rd_a[i]), int'(shadow[i]));
    fld = int'((shadow[i] >> LSB) & 32'h7);
    dv  = exp_div(ENC_T[i], fld);
    bad = (dv == 0) ? 1 : 0;
    if (bad == 1) dv = held[i];
    check(err_a[i] == bad[0], "R2", int'(err_a[i]), bad);
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      if (pulse_a[i]) seen = 1'b1;
      @(negedge clk);
    end
    check(int'(cur_a[i]) == dv, RO_T[i] ? "R7" : req_of(ENC_T[i]), int'(cur_a[i]), dv);
    held[i] = dv;
    hi = 0; pmiss = 0;
    for (int k = 0; k < dv; k++) begin
      if (pulse_a[i] != (k == dv - 1)) pmiss++;
      if (dclk_a[i]) hi++;
      @(negedge clk);
    end
    check(pmiss == 0, (dv == 1) ? "R3" : "R10", pmiss, 0);
    hexp = (dv + 1) / 2;
    if (dv >= 2) check(hi == hexp, "R11", hi, hexp);
  endtask

  initial begin
    for (int i = 0; i < N; i++) shadow[i] = RSTV;
    repeat (3) @(negedge clk);
    // R12: reset state
    for (int i = 0; i < N; i++) begin
      check(rd_a[i] == RSTV, "R12", int'(rd_a[i]), int'(RSTV));
      check(cur_a[i] == 16'd1 && pulse_a[i], "R12", int'(cur_a[i]), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      held[i] = exp_div(ENC_T[i], 1);
      check(int'(cur_a[i]) == held[i], "R12", int'(cur_a[i]), held[i]);
    end
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 8; f++) sweep_one(i, f);
    // R2: illegal zero after a legal value keeps that value
    sweep_one(1, 5);
    sweep_one(1, 0);
    check(int'(cur_a[1]) == 5, "R2", int'(cur_a[1]), 5);
    // R11: bypass divisor follows the input clock
    sweep_one(2, 0);
    @(posedge clk); #1;
    check(dclk_a[2] == 1'b1, "R11", int'(dclk_a[2]), 1);
    @(negedge clk); #1;
    check(dclk_a[2] == 1'b0, "R11", int'(dclk_a[2]), 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule